// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Nibble Receiver

This block is the host-side engine that receives bytes from a peripheral over the reverse channel of a legacy parallel port. The peripheral has no data bus it can drive, so it sends each byte as two 4-bit halves on four status input lines. Each half is paced by a two-wire handshake. The host drives a hold line, and the peripheral drives an active-low strobe.

A one-clock request starts one byte. The engine raises its reverse-mode output and drops the hold line to ask for the first half. It waits for the peripheral strobe to fall, lets the lines settle for a set number of clocks, and captures the half. It then raises the hold line and waits for the strobe to return high. The whole sequence then repeats for the second half. The assembled byte is presented with a one-clock valid pulse.

A peripheral that stops answering is caught by a timeout. The timeout returns the engine to idle and gives a one-clock error pulse. All port inputs are passed through a synchroniser before use.

Top module: `lpt_nibble_rx`

## Requirements
- R1: After reset, `host_hold_o` is 1, `rev_mode_o` is 0, and `byte_vld_o` and `tmo_err_o` are 0.
- R2: A request in idle drops `host_hold_o` to 0 and raises `rev_mode_o` after the next clock edge. `rev_mode_o` stays 1 until the byte completes or a timeout occurs, and `host_hold_o` is never 0 while `rev_mode_o` is 0.
- R3: `fwd_strobe_n_o` and `periph_init_n_o` are held at 1 at all times.
- R4: The engine acts on a falling edge of `pstb_n_i` seen through the synchroniser. After SETTLE_CYC clocks it captures the half and raises `host_hold_o`. This happens exactly SETTLE_CYC+3 clock edges after `pstb_n_i` goes low.
- R5: The captured half takes its bit 3 from `st_busy_i`, bit 2 from `st_pe_i`, bit 1 from `st_sel_i` and bit 0 from `st_fault_n_i`, with the line levels taken as they are.
- R6: The first half received forms bits 3..0 of the byte and the second half forms bits 7..4.
- R7: After raising `host_hold_o`, the engine waits for `pstb_n_i` to be high. It then drops `host_hold_o` for the second half, or, after the second half, returns to idle with `rev_mode_o` at 0.
- R8: `byte_vld_o` is high for exactly one clock per completed byte. That clock is the one in which `host_hold_o` rises for the second half.
- R9: If no strobe fall is seen for TMO_CYC clocks after `host_hold_o` drops, `tmo_err_o` pulses for one clock. The engine then returns to idle with `host_hold_o` at 1 and `rev_mode_o` at 0. If this happens during either half, no byte is delivered.
- R10: If `pstb_n_i` does not return high within TMO_CYC clocks after `host_hold_o` rises, the same timeout error and return to idle occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start receiving one byte (taken in idle) |
| byte_o | output | 8 | Assembled byte |
| byte_vld_o | output | 1 | One-clock valid for `byte_o` |
| tmo_err_o | output | 1 | One-clock timeout error pulse |
| host_hold_o | output | 1 | Handshake to peripheral: 0 = ready for a half, 1 = half taken |
| rev_mode_o | output | 1 | High while a reverse transfer is in progress |
| fwd_strobe_n_o | output | 1 | Forward data strobe, held inactive |
| periph_init_n_o | output | 1 | Peripheral init line, held inactive |
| pstb_n_i | input | 1 | Peripheral strobe, low marks valid half |
| st_busy_i | input | 1 | Status busy line, carries bit 3 / bit 7 |
| st_pe_i | input | 1 | Status paper-end line, carries bit 2 / bit 6 |
| st_sel_i | input | 1 | Status select line, carries bit 1 / bit 5 |
| st_fault_n_i | input | 1 | Status fault line, carries bit 0 / bit 4 |

## Verification
The bench builds the block with SETTLE_CYC = 2 and TMO_CYC = 48. With these values a full byte handshake takes only a few tens of clocks, so every one of the 256 byte values can be driven through the peripheral model. This exhausts the line-to-bit mapping and the half ordering. The small timeout also makes each timeout path (no first strobe, strobe stuck low, no second strobe) reachable in about fifty clocks. The count from a stimulus edge to the error pulse is then checked against the exact TMO_CYC value.

// File: rtl/nib_pkg.sv
// Package: shared widths and state encoding for the nibble receiver.
// Assumes: one byte is exactly two halves of NIB_W bits.
package nib_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_WAIT_HI = 2'd3
    } nib_state_t;
endpackage

// File: rtl/nib_sync.sv
// Module: multi-stage flop synchroniser for a bundle of asynchronous lines.
// Assumes: each line is quasi-static relative to clk, so bits need no
// mutual coherence beyond what the handshake protocol guarantees.
module nib_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            // first stage: sample the raw asynchronous lines
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d_i;
            end
        end else begin : g_next
            // later stages: shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nib_fsm.sv
// Module: handshake sequencer for the two halves of a reverse byte.
// Assumes: pstb_s_i is already synchronised; SETTLE_CYC >= 1, TMO_CYC >= 2.
// One counter serves both the settle delay and the timeout window.
module nib_fsm
    import nib_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int TMO_CYC    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic pstb_s_i,
    output logic host_hold_o,
    output logic rev_mode_o,
    output logic tmo_err_o,
    output logic cap_o,
    output logic cap_hi_o
);
    localparam int CNT_MAX = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST    = CW'(TMO_CYC - 1);

    nib_state_t    st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          half, half_nxt;
    logic          err_nxt;
    logic          pstb_q;
    logic          fall;

    // delayed copy of the synchronised strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pstb_q <= 1'b1;
        else        pstb_q <= pstb_s_i;
    end

    assign fall = pstb_q & ~pstb_s_i;

    // next-state, counter and capture decisions
    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt + 1'b1;
        half_nxt = half;
        err_nxt  = 1'b0;
        cap_o    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (req_i) begin
                    st_nxt   = ST_WAIT_LO;
                    half_nxt = 1'b0;
                end
            end
            ST_WAIT_LO: begin
                if (fall) begin
                    st_nxt  = ST_SETTLE;
                    cnt_nxt = '0;
                end else if (cnt == TMO_LAST) begin
                    st_nxt  = ST_IDLE;
                    cnt_nxt = '0;
                    err_nxt = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) begin
                    cap_o   = 1'b1;
                    st_nxt  = ST_WAIT_HI;
                    cnt_nxt = '0;
                end
            end
            ST_WAIT_HI: begin
                if (pstb_s_i) begin
                    cnt_nxt = '0;
                    if (half) begin
                        st_nxt = ST_IDLE;
                    end else begin
                        st_nxt   = ST_WAIT_LO;
                        half_nxt = 1'b1;
                    end
                end else if (cnt == TMO_LAST) begin
                    st_nxt  = ST_IDLE;
                    cnt_nxt = '0;
                    err_nxt = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state, counter, half index and error pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            half      <= 1'b0;
            tmo_err_o <= 1'b0;
        end else begin
            st        <= st_nxt;
            cnt       <= cnt_nxt;
            half      <= half_nxt;
            tmo_err_o <= err_nxt;
        end
    end

    assign cap_hi_o    = cap_o & half;
    assign host_hold_o = !((st == ST_WAIT_LO) || (st == ST_SETTLE));
    assign rev_mode_o  = (st != ST_IDLE);
endmodule

// File: rtl/nib_assemble.sv
// Module: joins two captured halves into a byte, low half first.
// Assumes: a high-half capture is always preceded by a low-half capture.
module nib_assemble
    import nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              cap_hi_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o
);
    logic [NIB_W-1:0] lo_q;

    // hold the low half, then emit the full byte with a one-clock valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            byte_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (cap_i && !cap_hi_i) begin
                lo_q <= nib_i;
            end
            if (cap_hi_i) begin
                byte_o <= {nib_i, lo_q};
                vld_o  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_nibble_rx.sv
// Module: top of the reverse-channel nibble receiver.
// Assumes: the peripheral holds its four status lines stable from before its
// strobe falls until the host hold line rises.
module lpt_nibble_rx
    import nib_pkg::*;
#(
    parameter int SETTLE_CYC  = 4,
    parameter int TMO_CYC     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              tmo_err_o,
    output logic              host_hold_o,
    output logic              rev_mode_o,
    output logic              fwd_strobe_n_o,
    output logic              periph_init_n_o,
    input  logic              pstb_n_i,
    input  logic              st_busy_i,
    input  logic              st_pe_i,
    input  logic              st_sel_i,
    input  logic              st_fault_n_i
);
    localparam int IN_W = NIB_W + 1;

    logic [IN_W-1:0]  raw_in, syn_in;
    logic             pstb_s;
    logic [NIB_W-1:0] nib_s;
    logic             cap, cap_hi;

    assign raw_in = {pstb_n_i, st_busy_i, st_pe_i, st_sel_i, st_fault_n_i};
    assign pstb_s = syn_in[IN_W-1];
    assign nib_s  = syn_in[NIB_W-1:0];

    nib_sync #(
        .W       (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({IN_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    nib_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .TMO_CYC    (TMO_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .pstb_s_i    (pstb_s),
        .host_hold_o (host_hold_o),
        .rev_mode_o  (rev_mode_o),
        .tmo_err_o   (tmo_err_o),
        .cap_o       (cap),
        .cap_hi_o    (cap_hi)
    );

    nib_assemble u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .cap_hi_i (cap_hi),
        .nib_i    (nib_s),
        .byte_o   (byte_o),
        .vld_o    (byte_vld_o)
    );

    assign fwd_strobe_n_o  = 1'b1;
    assign periph_init_n_o = 1'b1;
endmodule

// File: rtl/lpt_nibble_rx_chk.sv
// Module: protocol checker bound to the nibble receiver top.
// Assumes: observes top-level ports only.
module lpt_nibble_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_vld_o,
    input logic tmo_err_o,
    input logic host_hold_o,
    input logic rev_mode_o
);
    // R2
    hold_low_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hold_o |-> rev_mode_o);

    // R2
    start_drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rev_mode_o) |-> !host_hold_o);

    // R8
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R8
    vld_with_hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> (host_hold_o && rev_mode_o && $rose(host_hold_o)));

    // R9
    err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> (host_hold_o && !rev_mode_o && !byte_vld_o));

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |=> !tmo_err_o);
endmodule

bind lpt_nibble_rx lpt_nibble_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld_o  (byte_vld_o),
    .tmo_err_o   (tmo_err_o),
    .host_hold_o (host_hold_o),
    .rev_mode_o  (rev_mode_o)
);

// File: tb/tb_lpt_nibble_rx.sv
module tb_lpt_nibble_rx;
    localparam int SETTLE = 2;
    localparam int TMO    = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       pstb_n = 1'b1;
    logic       l_busy = 1'b1, l_pe = 1'b1, l_sel = 1'b1, l_fault = 1'b1;
    logic [7:0] byte_o;
    logic       byte_vld, tmo_err, host_hold, rev_mode, fstb_n, init_n;

    int checks = 0;
    int errors = 0;
    int vld_cnt = 0;
    logic [7:0] last_byte = 8'h00;

    always #10 clk = ~clk;

    lpt_nibble_rx #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req),
        .byte_o          (byte_o),
        .byte_vld_o      (byte_vld),
        .tmo_err_o       (tmo_err),
        .host_hold_o     (host_hold),
        .rev_mode_o      (rev_mode),
        .fwd_strobe_n_o  (fstb_n),
        .periph_init_n_o (init_n),
        .pstb_n_i        (pstb_n),
        .st_busy_i       (l_busy),
        .st_pe_i         (l_pe),
        .st_sel_i        (l_sel),
        .st_fault_n_i    (l_fault)
    );

    // record each delivered byte
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            vld_cnt++;
            last_byte = byte_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    // peripheral model: deliver one half, timing the hold-line rise
    task automatic send_nib(input logic [3:0] n, input bit last);
        int cnt;
        while (host_hold) @(negedge clk);
        {l_busy, l_pe, l_sel, l_fault} = n;
        repeat (2) @(negedge clk);
        pstb_n = 1'b0;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!host_hold && cnt < TMO);
        chk(cnt == SETTLE + 3, "R4 settle to hold rise", cnt, SETTLE + 3);
        if (last) chk(byte_vld == 1'b1, "R8 valid with second hold rise", int'(byte_vld), 1);
        @(negedge clk);
        pstb_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        int v0;
        v0 = vld_cnt;
        pulse_req();
        chk(!host_hold && rev_mode, "R2 request starts transfer",
            int'({host_hold, rev_mode}), 1);
        send_nib(b[3:0], 1'b0);
        send_nib(b[7:4], 1'b1);
        repeat (5) @(negedge clk);
        chk(!rev_mode && host_hold, "R7 idle after second half",
            int'({host_hold, rev_mode}), 2);
        chk(vld_cnt == v0 + 1, "R8 one valid per byte", vld_cnt - v0, 1);
        chk(last_byte == b, "R5/R6 byte value", int'(last_byte), int'(b));
    endtask

    // count clocks from the current observation point until the error pulse
    task automatic count_to_err(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmo_err && n < TMO + 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual 150000 cycles expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        int v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(host_hold && !rev_mode, "R1 reset handshake lines",
            int'({host_hold, rev_mode}), 2);
        chk(!byte_vld && !tmo_err, "R1 reset pulses", int'({byte_vld, tmo_err}), 0);
        chk(fstb_n && init_n, "R3 unused lines high", int'({fstb_n, init_n}), 3);

        // exhaustive sweep covers every line-to-bit mapping (R5) and ordering (R6)
        for (int b = 0; b < 256; b++) begin
            send_byte(8'(b));
        end
        chk(fstb_n && init_n, "R3 unused lines high after sweep", int'({fstb_n, init_n}), 3);

        // R9: no strobe at all for the first half
        v0 = vld_cnt;
        pulse_req();
        count_to_err(n);
        chk(n == TMO, "R9 timeout waiting for first strobe", n, TMO);
        chk(host_hold && !rev_mode, "R9 idle after timeout", int'({host_hold, rev_mode}), 2);
        @(negedge clk);
        chk(!tmo_err, "R9 error is one clock", int'(tmo_err), 0);

        // R10: strobe falls but never returns high
        pulse_req();
        {l_busy, l_pe, l_sel, l_fault} = 4'h6;
        repeat (2) @(negedge clk);
        pstb_n = 1'b0;
        while (!host_hold) @(negedge clk);
        count_to_err(n);
        chk(n == TMO, "R10 timeout waiting for strobe release", n, TMO);
        chk(host_hold && !rev_mode, "R10 idle after timeout", int'({host_hold, rev_mode}), 2);
        pstb_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: first half completes, second strobe never comes
        pulse_req();
        send_nib(4'h9, 1'b0);
        while (host_hold) @(negedge clk);
        count_to_err(n);
        chk(n == TMO, "R9 timeout in second half", n, TMO);
        repeat (3) @(negedge clk);
        chk(vld_cnt == v0, "R9 no byte after timeouts", vld_cnt - v0, 0);

        // recovery after timeouts
        send_byte(8'h5A);
        send_byte(8'hC3);

        summary();
        $finish;
    end
endmodule